// File: doc/BRIEF.md
# Column-Redundant RAM Block

This block is a small storage array of sixteen one-bit columns, each thirty-two rows deep, plus one spare column. The spare can stand in for any single primary column that is defective. A five-bit configuration value, loaded once after reset, names the column to replace. While a column is replaced, reads take that bit position from the spare, and writes steer the data meant for that column into the spare as well. A defective primary column is therefore never seen at the outputs.

Two data paths share the array. The wide path writes and reads a whole sixteen-bit row. The narrow path writes one four-bit nibble, chosen by a nibble select, and reads the nibble chosen by the same select. The spare's write input takes its bit from whichever path is active. The spare is written only when the write actually covers the replaced column. Two inputs model stuck-at defects in the primary columns, so a bench can show the substitution working at the ports.

Top module: `spc_ram_block`

## Requirements
- R1: During reset and on the first cycle after it, `rdata_wide` and `rdata_nib` are zero, and the configuration is 16, which means replacement is disabled.
- R2: A read samples `addr` at a rising edge, and `rdata_wide` holds the row from that edge onward. When a write and a read of the same row occur in the same cycle, the read returns the old contents.
- R3: A narrow write (`wr_en`=1, `wr_wide`=0) with `nib_sel`=n stores `wdata_nib` into columns 4n to 4n+3 of the row, which are bits [4n+3:4n]. All other columns of the row are left unchanged.
- R4: `rdata_nib` equals bits [4n+3:4n] of the same corrected row that `rdata_wide` shows, where n is `nib_sel` at the read edge. It has the same latency as `rdata_wide`.
- R5: With the configuration in the range 0 to 15, bit k of both read outputs comes from the spare column, where k is the configured value. A stuck-at defect on primary column k is then not visible on wide or narrow reads.
- R6: With a configuration of 16 or more, every bit comes from its primary column, so an injected defect is visible.
- R7: On a wide write, the spare stores `wdata_wide[k]`. On a narrow write whose nibble contains column k, the spare stores `wdata_nib[k mod 4]`.
- R8: A narrow write to a nibble that does not contain column k leaves the spare unchanged.
- R9: A value written with `cfg_we` governs reads sampled from the next rising edge onward. The configuration holds while `cfg_we` is low. If the spare was last loaded for another column, the newly chosen bit shows the spare's existing contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load the replacement configuration |
| cfg_sel | input | 5 | Column to replace (0..15); 16 or more disables replacement |
| wr_en | input | 1 | Write the addressed row |
| wr_wide | input | 1 | 1 = wide write of 16 bits, 0 = narrow write of one nibble |
| addr | input | 5 | Row address for read and write |
| nib_sel | input | 2 | Nibble for narrow write and narrow read |
| wdata_wide | input | 16 | Wide-path write data |
| wdata_nib | input | 4 | Narrow-path write data |
| flt_en | input | 16 | Defect model: primary column k reads as `flt_val[k]` |
| flt_val | input | 16 | Defect model: stuck-at value per column |
| rdata_wide | output | 16 | Corrected row read, registered |
| rdata_nib | output | 4 | Corrected nibble read, registered |

## Verification
Every read result is due on the rising edge that samples `addr` and `nib_sel`. A configuration load is in effect for the read sampled one edge after `cfg_we`. A write is visible to reads issued on later edges, while a read issued on the same edge as the write still returns the old row. The driver queues the expected wide and narrow values on the cycle it issues a read. Those values come from a model of the intended row contents, the spare's own contents and the injected defects. The monitor pops the queue at the falling edge after the sampling edge, so each comparison sits exactly one register stage behind its stimulus.

// File: rtl/spc_pkg.sv
// Shared helpers for the column-redundant RAM block.
// Assumes column counts fit in 32 bits.
package spc_pkg;

    // True when a configuration value names a real column.
    function automatic logic col_in_range(input int unsigned sel, input int unsigned ncols);
        return sel < ncols;
    endfunction

endpackage

// File: rtl/spc_column.sv
// One bit-wide storage column of ROWS rows with a combinational read.
// Write occurs at the clock edge, so a read of the same row in the
// same cycle sees the old bit. The stuck inputs model a physical
// defect on the column's output; tie them low for a healthy column.
// Assumes ROWS is a power of two.
module spc_column #(
    parameter int ROWS = 32,
    localparam int AW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic          din,
    input  logic          stuck_en,
    input  logic          stuck_val,
    output logic          dout
);

    logic [ROWS-1:0] bits;

    // Store the incoming bit in the addressed row.
    always_ff @(posedge clk) begin
        if (we) begin
            bits[addr] <= din;
        end
    end

    // Read the addressed row, overridden by the defect model.
    always_comb begin
        dout = stuck_en ? stuck_val : bits[addr];
    end

endmodule

// File: rtl/spc_spare_sel.sv
// Spare column input selection and write enable.
// Picks the bit meant for the replaced column from the wide or the
// narrow write path, and enables the spare only when the write covers
// that column. Assumes NIB and COLS are powers of two and COLS > NIB.
module spc_spare_sel
    import spc_pkg::*;
#(
    parameter int COLS = 16,
    parameter int NIB  = 4,
    localparam int CIW  = $clog2(COLS),
    localparam int CW   = CIW + 1,
    localparam int NLOG = $clog2(NIB),
    localparam int NSW  = CIW - NLOG
) (
    input  logic            wr_en,
    input  logic            wr_wide,
    input  logic [NSW-1:0]  nib_sel,
    input  logic [COLS-1:0] wdata_wide,
    input  logic [NIB-1:0]  wdata_nib,
    input  logic [CW-1:0]   cfg_q,
    output logic            spare_we,
    output logic            spare_din
);

    logic           active;
    logic [CIW-1:0] col_idx;
    logic [NSW-1:0] col_nib;
    logic [NLOG-1:0] col_pos;

    // Split the configured column into nibble number and position.
    always_comb begin
        active  = col_in_range(32'(cfg_q), COLS);
        col_idx = cfg_q[CIW-1:0];
        col_nib = col_idx[CIW-1:NLOG];
        col_pos = col_idx[NLOG-1:0];
    end

    // Choose the spare's data and decide whether this write reaches it.
    always_comb begin
        spare_din = wr_wide ? wdata_wide[col_idx] : wdata_nib[col_pos];
        spare_we  = wr_en && active && (wr_wide || (col_nib == nib_sel));
    end

endmodule

// File: rtl/spc_read_override.sv
// Read path: one 2-input override mux per primary column, a nibble
// selector, and the output registers. The configuration is assumed
// static during normal operation, so the muxes cost delay only.
module spc_read_override
    import spc_pkg::*;
#(
    parameter int COLS = 16,
    parameter int NIB  = 4,
    localparam int CIW  = $clog2(COLS),
    localparam int CW   = CIW + 1,
    localparam int NLOG = $clog2(NIB),
    localparam int NSW  = CIW - NLOG,
    localparam int NNIB = COLS / NIB
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] prim_bits,
    input  logic            spare_bit,
    input  logic [CW-1:0]   cfg_q,
    input  logic [NSW-1:0]  nib_sel,
    output logic [COLS-1:0] rdata_wide,
    output logic [NIB-1:0]  rdata_nib
);

    logic            use_spare;
    logic [CIW-1:0]  col_idx;
    logic [COLS-1:0] fixed;
    logic [NIB-1:0]  nib_pick;

    // Decode whether replacement is on and which column it hits.
    always_comb begin
        use_spare = col_in_range(32'(cfg_q), COLS);
        col_idx   = cfg_q[CIW-1:0];
    end

    // Per-column override mux.
    for (genvar c = 0; c < COLS; c++) begin : g_ovr
        assign fixed[c] = (use_spare && (col_idx == CIW'(c))) ? spare_bit : prim_bits[c];
    end

    // Select the requested nibble from the corrected row.
    always_comb begin
        nib_pick = '0;
        for (int n = 0; n < NNIB; n++) begin
            if (nib_sel == NSW'(n)) begin
                nib_pick = fixed[n*NIB +: NIB];
            end
        end
    end

    // Register both read outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_wide <= '0;
            rdata_nib  <= '0;
        end else begin
            rdata_wide <= fixed;
            rdata_nib  <= nib_pick;
        end
    end

endmodule

// File: rtl/spc_ram_block.sv
// Column-redundant RAM block: COLS primary columns of ROWS rows and
// one spare column. A configuration register names the column the
// spare replaces (COLS or above disables replacement). Writes come
// from a wide path or a one-nibble narrow path. Assumes ROWS, COLS
// and NIB are powers of two and COLS > NIB.
module spc_ram_block #(
    parameter int COLS = 16,
    parameter int ROWS = 32,
    parameter int NIB  = 4,
    localparam int AW   = $clog2(ROWS),
    localparam int CIW  = $clog2(COLS),
    localparam int CW   = CIW + 1,
    localparam int NLOG = $clog2(NIB),
    localparam int NSW  = CIW - NLOG
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CW-1:0]   cfg_sel,
    input  logic            wr_en,
    input  logic            wr_wide,
    input  logic [AW-1:0]   addr,
    input  logic [NSW-1:0]  nib_sel,
    input  logic [COLS-1:0] wdata_wide,
    input  logic [NIB-1:0]  wdata_nib,
    input  logic [COLS-1:0] flt_en,
    input  logic [COLS-1:0] flt_val,
    output logic [COLS-1:0] rdata_wide,
    output logic [NIB-1:0]  rdata_nib
);

    logic [CW-1:0]   cfg_q;
    logic [COLS-1:0] col_we;
    logic [COLS-1:0] col_din;
    logic [COLS-1:0] prim_bits;
    logic            spare_we;
    logic            spare_din;
    logic            spare_bit;

    // Replacement configuration register, disabled after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CW'(COLS);
        end else if (cfg_we) begin
            cfg_q <= cfg_sel;
        end
    end

    // Primary columns with their per-column write steering.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign col_we[c]  = wr_en && (wr_wide || (nib_sel == NSW'(c / NIB)));
        assign col_din[c] = wr_wide ? wdata_wide[c] : wdata_nib[c % NIB];

        spc_column #(.ROWS(ROWS)) u_col (
            .clk       (clk),
            .we        (col_we[c]),
            .addr      (addr),
            .din       (col_din[c]),
            .stuck_en  (flt_en[c]),
            .stuck_val (flt_val[c]),
            .dout      (prim_bits[c])
        );
    end

    spc_spare_sel #(.COLS(COLS), .NIB(NIB)) u_sel (
        .wr_en      (wr_en),
        .wr_wide    (wr_wide),
        .nib_sel    (nib_sel),
        .wdata_wide (wdata_wide),
        .wdata_nib  (wdata_nib),
        .cfg_q      (cfg_q),
        .spare_we   (spare_we),
        .spare_din  (spare_din)
    );

    spc_column #(.ROWS(ROWS)) u_spare (
        .clk       (clk),
        .we        (spare_we),
        .addr      (addr),
        .din       (spare_din),
        .stuck_en  (1'b0),
        .stuck_val (1'b0),
        .dout      (spare_bit)
    );

    spc_read_override #(.COLS(COLS), .NIB(NIB)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .prim_bits  (prim_bits),
        .spare_bit  (spare_bit),
        .cfg_q      (cfg_q),
        .nib_sel    (nib_sel),
        .rdata_wide (rdata_wide),
        .rdata_nib  (rdata_nib)
    );

endmodule

// File: rtl/spc_ram_block_chk.sv
// Property checker for spc_ram_block, attached by bind below.
module spc_ram_block_chk #(
    parameter int COLS = 16,
    parameter int NIB  = 4,
    localparam int CIW  = $clog2(COLS),
    localparam int CW   = CIW + 1,
    localparam int NLOG = $clog2(NIB),
    localparam int NSW  = CIW - NLOG
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_we,
    input logic [CW-1:0]   cfg_sel,
    input logic            wr_en,
    input logic            wr_wide,
    input logic [NSW-1:0]  nib_sel,
    input logic [COLS-1:0] wdata_wide,
    input logic [NIB-1:0]  wdata_nib,
    input logic [COLS-1:0] rdata_wide,
    input logic [NIB-1:0]  rdata_nib,
    input logic [CW-1:0]   cfg_q,
    input logic            spare_we,
    input logic            spare_din
);

    // R1: outputs cleared by reset.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (rdata_wide == '0 && rdata_nib == '0));

    // R4: narrow read output is a slice of the wide read output.
    a_r4_nib_slice: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_nib == rdata_wide[int'($past(nib_sel))*NIB +: NIB]);

    // R7: spare data on a wide write comes from the replaced column's bit.
    a_r7_spare_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (spare_we && wr_wide) |-> (spare_din == wdata_wide[cfg_q[CIW-1:0]]));

    // R7: spare data on a narrow write comes from the nibble position.
    a_r7_spare_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (spare_we && !wr_wide) |-> (spare_din == wdata_nib[cfg_q[NLOG-1:0]]));

    // R8: narrow write to another nibble never touches the spare.
    a_r8_spare_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_wide && (nib_sel != cfg_q[CIW-1:NLOG])) |-> !spare_we);

    // R9: configuration load and hold.
    a_r9_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == $past(cfg_sel)));

    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));

endmodule

bind spc_ram_block spc_ram_block_chk #(.COLS(COLS), .NIB(NIB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .wr_en      (wr_en),
    .wr_wide    (wr_wide),
    .nib_sel    (nib_sel),
    .wdata_wide (wdata_wide),
    .wdata_nib  (wdata_nib),
    .rdata_wide (rdata_wide),
    .rdata_nib  (rdata_nib),
    .cfg_q      (cfg_q),
    .spare_we   (spare_we),
    .spare_din  (spare_din)
);

// File: tb/spc_ram_block_bench.sv
// Scoreboard bench for spc_ram_block.
module spc_ram_block_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_sel = '0;
    logic        wr_en = 1'b0;
    logic        wr_wide = 1'b0;
    logic [4:0]  addr = '0;
    logic [1:0]  nib_sel = '0;
    logic [15:0] wdata_wide = '0;
    logic [3:0]  wdata_nib = '0;
    logic [15:0] flt_en = '0;
    logic [15:0] flt_val = '0;
    logic [15:0] rdata_wide;
    logic [3:0]  rdata_nib;

    int checks = 0;
    int failures = 0;
    logic issue = 1'b0;

    logic [15:0] model [32];
    logic        spare_m [32];
    int          cfg_m = 16;

    logic [15:0] q_w [$];
    logic [3:0]  q_n [$];
    string       q_t [$];

    always #5 clk = ~clk;

    spc_ram_block u_spc_ram_block (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .wr_en(wr_en), .wr_wide(wr_wide), .addr(addr), .nib_sel(nib_sel),
        .wdata_wide(wdata_wide), .wdata_nib(wdata_nib),
        .flt_en(flt_en), .flt_val(flt_val),
        .rdata_wide(rdata_wide), .rdata_nib(rdata_nib)
    );

    // Expected corrected row from intended data, defects and spare.
    function automatic logic [15:0] exp_word(input int a);
        logic [15:0] w;
        w = model[a];
        for (int c = 0; c < 16; c++) begin
            if (flt_en[c]) w[c] = flt_val[c];
        end
        if (cfg_m < 16) w[cfg_m] = spare_m[a];
        return w;
    endfunction

    function automatic logic [15:0] pat(input int a, input int k);
        return 16'((a * 16'h1357) ^ (k * 16'h0f0f) ^ 16'ha5c3);
    endfunction

    // One cycle of stimulus: optional write and optional read.
    task automatic op(input bit w, input bit wide, input int a, input int n,
                      input logic [15:0] wd, input logic [3:0] wn,
                      input bit r, input string tag);
        logic [15:0] e;
        addr = 5'(a);
        nib_sel = 2'(n);
        wr_en = w;
        wr_wide = wide;
        wdata_wide = wd;
        wdata_nib = wn;
        issue = r;
        if (r) begin
            e = exp_word(a);
            q_w.push_back(e);
            q_n.push_back(e[n*4 +: 4]);
            q_t.push_back(tag);
        end
        if (w) begin
            if (cfg_m < 16) begin
                if (wide) spare_m[a] = wd[cfg_m];
                else if (n == cfg_m / 4) spare_m[a] = wn[cfg_m % 4];
            end
            if (wide) model[a] = wd;
            else model[a][n*4 +: 4] = wn;
        end
        @(negedge clk);
        wr_en = 1'b0;
        issue = 1'b0;
    endtask

    task automatic wr_w(input int a, input logic [15:0] d);
        op(1, 1, a, 0, d, 4'h0, 0, "");
    endtask

    task automatic wr_n(input int a, input int n, input logic [3:0] d);
        op(1, 0, a, n, 16'h0, d, 0, "");
    endtask

    task automatic rd(input int a, input int n, input string tag);
        op(0, 0, a, n, 16'h0, 4'h0, 1, tag);
    endtask

    task automatic set_cfg(input int v);
        cfg_we = 1'b1;
        cfg_sel = 5'(v);
        cfg_m = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Monitor: compare each issued read one edge after it was sampled.
    initial begin
        logic iss;
        logic [15:0] ew;
        logic [3:0] en;
        string t;
        forever begin
            @(posedge clk);
            iss = issue;
            @(negedge clk);
            if (iss) begin
                ew = q_w.pop_front();
                en = q_n.pop_front();
                t = q_t.pop_front();
                checks++;
                if (rdata_wide !== ew || rdata_nib !== en) begin
                    failures++;
                    $display("FAIL %s wide=%h exp=%h nib=%h exp=%h", t, rdata_wide, ew, rdata_nib, en);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports.
        checks++;
        if (rdata_wide !== 16'h0 || rdata_nib !== 4'h0) begin
            failures++;
            $display("FAIL R1 wide=%h exp=0000 nib=%h exp=0", rdata_wide, rdata_nib);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R4: wide writes then wide and narrow reads, disabled mode.
        for (int a = 0; a < 8; a++) wr_w(a, pat(a, 1));
        for (int a = 0; a < 8; a++) rd(a, a % 4, "R2_R4");

        // R3: narrow write touches only its nibble.
        wr_n(3, 2, 4'hA);
        rd(3, 2, "R3");
        wr_n(3, 0, 4'h5);
        rd(3, 3, "R3");

        // R2: same-cycle write and read returns the old row, then new.
        op(1, 1, 5, 1, 16'h1234, 4'h0, 1, "R2");
        rd(5, 1, "R2");

        // R6: defect visible with replacement disabled.
        wr_w(2, 16'h0000);
        flt_en = 16'h0040;
        flt_val = 16'h0040;
        rd(2, 1, "R6");

        // R5: replace column 6; rewrite rows then read through defect.
        set_cfg(6);
        for (int a = 0; a < 8; a++) wr_w(a, pat(a, 2));
        for (int a = 0; a < 8; a++) rd(a, 1, "R5");
        flt_val = 16'h0000;
        for (int a = 0; a < 8; a++) rd(a, a % 4, "R5");

        // R7: narrow write into the replaced nibble feeds the spare.
        wr_n(1, 1, 4'b0100);
        rd(1, 1, "R7");
        wr_n(1, 1, 4'b1011);
        rd(1, 1, "R7");

        // R8: narrow writes to other nibbles leave the spare alone.
        flt_val = 16'h0040;
        wr_n(4, 0, 4'hF);
        wr_n(4, 3, 4'h0);
        wr_n(4, 2, 4'h9);
        rd(4, 1, "R8");

        // R9: switch to column 9; spare's existing bits appear there.
        flt_en = 16'h0000;
        set_cfg(9);
        rd(4, 2, "R9");
        for (int a = 0; a < 8; a++) rd(a, 2, "R9");

        // R5 / R7 boundaries: columns 15 and 0, narrow and wide.
        set_cfg(15);
        flt_en = 16'h8000;
        flt_val = 16'h0000;
        for (int a = 0; a < 32; a++) wr_w(a, pat(a, 3) | 16'h8000);
        for (int a = 0; a < 32; a += 5) rd(a, 3, "R5");
        wr_n(7, 3, 4'b0111);
        rd(7, 3, "R7");
        set_cfg(0);
        flt_en = 16'h0001;
        flt_val = 16'h0001;
        for (int a = 0; a < 32; a++) wr_w(a, pat(a, 4) & 16'hfffe);
        for (int a = 0; a < 32; a += 3) rd(a, 0, "R5");
        wr_n(9, 0, 4'b1110);
        rd(9, 0, "R7");

        // R6: values above 16 also disable replacement.
        set_cfg(20);
        rd(9, 0, "R6");
        rd(10, 0, "R6");
        set_cfg(16);
        flt_en = 16'h0000;
        wr_w(11, 16'hbeef);
        rd(11, 3, "R6");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule